// File: doc/BRIEF.md
# Interrupt Cause and Mask Unit

This block gathers seven single-bit event sources into one interrupt line for a parent controller. Each event that is high on a clock edge sets its own bit in a cause register. A mask register selects which cause bits count as pending. The unit sends the OR of the pending bits to the parent as a registered summary interrupt. It also reports, as a read-only status, the index of the highest-numbered pending source.

Software reaches both registers over a 32-bit register bus. Reads are combinational, and a write takes effect at the clock edge on which it is presented. Each register bit simply holds the value last written to it. Writing a 1 to a cause bit raises that interrupt from software, and writing a 0 clears it. A source that is high in the same cycle still sets its bit, whatever the write carries.

Top module: `irq_cause_unit`

## Requirements
- R1: After reset the cause register, the mask register, the summary interrupt and the pending-valid flag are all zero.
- R2: A write to the cause register (address 0x50) with no event high loads bits 6..0 exactly from the write data, so a 0 clears a bit and a 1 sets it. The new value can be read back on the next cycle.
- R3: A write to the mask register (address 0x54) loads bits 6..0 from the write data. Without such a write, the mask keeps its value.
- R4: An event input that is high on a clock edge sets its cause bit (bit i for input i). The bit stays set after the event drops.
- R5: When an event is high in the same cycle as a cause write that carries 0 in that bit, the bit ends up set.
- R6: The pending set is the cause register ANDed with the mask, where a mask bit of 1 enables its source. The pending-valid flag is high exactly when this set is non-zero.
- R7: When several sources are pending, the status index gives the highest-numbered one, as a binary value 0..6.
- R8: The summary interrupt equals the OR of the pending set one clock later, so it lags a register change by one cycle.
- R9: Bits 31..7 of both registers read as zero, and writing them has no effect.
- R10: A bus write to any other address changes neither register, and a read of any other address returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evtIn | input | 7 | Event sources, sampled as levels on every clock edge |
| busSel | input | 1 | Register bus access strobe |
| busWr | input | 1 | Access is a write when high |
| busAddr | input | 8 | Byte address of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data (combinational) |
| irqOut | output | 1 | Registered summary interrupt to the parent |
| pendIdx | output | 3 | Index of the highest pending source |
| pendValid | output | 1 | High when at least one source is pending |

## Verification
The pending logic is driven with several cause/mask pairs. In one, the cause and the mask are disjoint, which shows that masking removes sources. In another, bits 0 and 6 are both pending, and in a third bit 0 is pending alone; together these separate a highest-first encoder from a lowest-first one. Events are applied alone and together with a cause write of zero, which shows that the bit is sticky and that an event wins over the write. All-ones data and writes to an unused address show that out-of-range bits and other addresses leave both registers untouched. The summary line is sampled just after a mask change and again one cycle later, which confirms the one-cycle lag.

// File: rtl/irq_cause_pkg.sv
package irq_cause_pkg;
  // strobes from the bus decoder to the register datapath
  typedef struct packed {
    logic wrCause;
    logic wrMask;
    logic selCause;
    logic selMask;
  } regStrobe_t;
endpackage

// File: rtl/irq_cause_ctrl.sv
module irq_cause_ctrl
  import irq_cause_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CAUSE_OFS = 8'h50,
  parameter logic [ADDR_W-1:0] MASK_OFS = 8'h54
) (
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  output regStrobe_t        strb
);
  logic hitCause;
  logic hitMask;

  assign hitCause = busSel && (busAddr == CAUSE_OFS);
  assign hitMask  = busSel && (busAddr == MASK_OFS);

  always_comb begin
    strb.selCause = hitCause;
    strb.selMask  = hitMask;
    strb.wrCause  = hitCause && busWr;
    strb.wrMask   = hitMask && busWr;
  end
endmodule

// File: rtl/irq_cause_dpath.sv
module irq_cause_dpath
  import irq_cause_pkg::*;
#(
  parameter int NUM_SRC = 7,
  parameter int DATA_W = 32,
  parameter int IDX_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] evtIn,
  input  regStrobe_t         strb,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  output logic [NUM_SRC-1:0] causeQ,
  output logic [NUM_SRC-1:0] maskQ,
  output logic               irqOut,
  output logic [IDX_W-1:0]   pendIdx,
  output logic               pendValid
);
  logic [NUM_SRC-1:0] causeNext;
  logic [NUM_SRC-1:0] pending;

  // per-bit next state: a live event outranks the software value
  for (genvar b = 0; b < NUM_SRC; b++) begin : g_causeBit
    assign causeNext[b] = evtIn[b] ? 1'b1
                        : (strb.wrCause ? busWdata[b] : causeQ[b]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      causeQ <= '0;
      maskQ  <= '0;
      irqOut <= 1'b0;
    end else begin
      causeQ <= causeNext;
      if (strb.wrMask) maskQ <= busWdata[NUM_SRC-1:0];
      irqOut <= |pending;
    end
  end

  assign pending = causeQ & maskQ;

  // highest index wins: later iterations overwrite earlier ones
  always_comb begin
    pendIdx   = '0;
    pendValid = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (pending[i]) begin
        pendIdx   = IDX_W'(i);
        pendValid = 1'b1;
      end
    end
  end

  always_comb begin
    busRdata = '0;
    if (strb.selCause)     busRdata = DATA_W'(causeQ);
    else if (strb.selMask) busRdata = DATA_W'(maskQ);
  end
endmodule

// File: rtl/irq_cause_unit.sv
module irq_cause_unit
  import irq_cause_pkg::*;
#(
  parameter int NUM_SRC = 7,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CAUSE_OFS = 8'h50,
  parameter logic [ADDR_W-1:0] MASK_OFS = 8'h54,
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] evtIn,
  input  logic               busSel,
  input  logic               busWr,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  output logic               irqOut,
  output logic [IDX_W-1:0]   pendIdx,
  output logic               pendValid
);
  regStrobe_t         strb;
  logic [NUM_SRC-1:0] causeQ;
  logic [NUM_SRC-1:0] maskQ;

  irq_cause_ctrl #(
    .ADDR_W(ADDR_W), .CAUSE_OFS(CAUSE_OFS), .MASK_OFS(MASK_OFS)
  ) u_ctrl (
    .busSel(busSel), .busWr(busWr), .busAddr(busAddr), .strb(strb)
  );

  irq_cause_dpath #(
    .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .IDX_W(IDX_W)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .strb(strb),
    .busWdata(busWdata), .busRdata(busRdata),
    .causeQ(causeQ), .maskQ(maskQ), .irqOut(irqOut),
    .pendIdx(pendIdx), .pendValid(pendValid)
  );
endmodule

// File: rtl/irq_cause_checker.sv
module irq_cause_checker
  import irq_cause_pkg::*;
#(
  parameter int NUM_SRC = 7,
  parameter int DATA_W = 32,
  parameter int IDX_W = 3
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] evtIn,
  input regStrobe_t         strb,
  input logic [DATA_W-1:0]  busWdata,
  input logic [DATA_W-1:0]  busRdata,
  input logic [NUM_SRC-1:0] causeQ,
  input logic [NUM_SRC-1:0] maskQ,
  input logic               irqOut,
  input logic [IDX_W-1:0]   pendIdx,
  input logic               pendValid
);
  logic [NUM_SRC-1:0] pend;
  assign pend = causeQ & maskQ;

  assert_cause_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrCause && evtIn == '0) |=> causeQ == $past(busWdata[NUM_SRC-1:0]));

  assert_mask_load_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrMask |=> maskQ == $past(busWdata[NUM_SRC-1:0]));

  assert_mask_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrMask |=> $stable(maskQ));

  // R4 and R5: every sampled event is set in the cause register
  assert_evt_sets_R4: assert property (@(posedge clk) disable iff (!rstN)
    (evtIn != '0) |=> ((causeQ & $past(evtIn)) == $past(evtIn)));

  assert_valid_R6: assert property (@(posedge clk) disable iff (!rstN)
    pendValid == (pend != '0));

  assert_highest_R7: assert property (@(posedge clk) disable iff (!rstN)
    pendValid |-> ((32'(pendIdx) < NUM_SRC) && ((pend >> pendIdx) == NUM_SRC'(1))));

  assert_irq_lag_R8: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> irqOut == $past(pend != '0));

  assert_upper_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    busRdata[DATA_W-1:NUM_SRC] == '0);
endmodule

bind irq_cause_unit irq_cause_checker #(
  .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .IDX_W(IDX_W)
) u_irqChk (
  .clk(clk), .rstN(rstN), .evtIn(evtIn), .strb(strb),
  .busWdata(busWdata), .busRdata(busRdata),
  .causeQ(causeQ), .maskQ(maskQ), .irqOut(irqOut),
  .pendIdx(pendIdx), .pendValid(pendValid)
);

// File: tb/test_irq_cause_unit.sv
module test_irq_cause_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 5000;
  localparam logic [7:0] A_CAUSE = 8'h50;
  localparam logic [7:0] A_MASK = 8'h54;
  localparam logic [7:0] A_OTHER = 8'h58;

  // observation kinds
  localparam int K_RDATA = 0;
  localparam int K_IRQ = 1;
  localparam int K_STAT = 2;

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } sbItem_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [6:0]  evtIn = '0;
  logic        busSel = 1'b0;
  logic        busWr = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irqOut;
  logic [2:0]  pendIdx;
  logic        pendValid;

  int      checks = 0;
  int      fails = 0;
  int      cycles = 0;
  sbItem_t sbQ[$];
  event    sampleEv;

  irq_cause_unit i_irq_cause_unit (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .irqOut(irqOut), .pendIdx(pendIdx), .pendValid(pendValid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WATCHDOG);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  // monitor: pops the expected item and compares with the observed port
  initial begin
    forever begin
      @(sampleEv);
      #1;
      while (sbQ.size() > 0) begin
        sbItem_t it;
        logic [31:0] act;
        it = sbQ.pop_front();
        case (it.kind)
          K_RDATA: act = busRdata;
          K_IRQ:   act = {31'd0, irqOut};
          default: act = {28'd0, pendValid, pendIdx};
        endcase
        checks++;
        if (act !== it.exp) begin
          fails++;
          $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  // driver: called just after a falling edge, pushes the expectation
  task automatic expectObs(input int kind, input logic [7:0] a,
                           input logic [31:0] e, input string tag);
    sbItem_t it;
    if (kind == K_RDATA) begin
      busSel = 1'b1; busWr = 1'b0; busAddr = a;
    end
    it.kind = kind; it.exp = e; it.tag = tag;
    sbQ.push_back(it);
    -> sampleEv;
    #2;
    busSel = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    expectObs(K_RDATA, A_CAUSE, 32'h0, "R1 cause after reset");
    expectObs(K_RDATA, A_MASK, 32'h0, "R1 mask after reset");
    expectObs(K_IRQ, 8'h0, 32'h0, "R1 irq after reset");
    expectObs(K_STAT, 8'h0, 32'h0, "R1 status after reset");

    // R2 exact load, set and clear
    busWrite(A_CAUSE, 32'h7F);
    expectObs(K_RDATA, A_CAUSE, 32'h7F, "R2 cause all set");
    busWrite(A_CAUSE, 32'h05);
    expectObs(K_RDATA, A_CAUSE, 32'h05, "R2 cause partial clear");
    // R9 upper bits ignored
    busWrite(A_CAUSE, 32'hFFFF_FFFF);
    expectObs(K_RDATA, A_CAUSE, 32'h7F, "R9 cause upper bits");
    busWrite(A_CAUSE, 32'h05);

    // R3 mask load, R9 on mask
    busWrite(A_MASK, 32'hFFFF_FF0A);
    expectObs(K_RDATA, A_MASK, 32'h0A, "R3 R9 mask load");
    // R6 disjoint cause and mask -> nothing pending
    expectObs(K_STAT, 8'h0, 32'h0, "R6 disjoint not pending");
    @(negedge clk);
    expectObs(K_IRQ, 8'h0, 32'h0, "R6 irq low when masked");
    expectObs(K_RDATA, A_MASK, 32'h0A, "R3 mask holds");

    // R7 and R8: enable all, cause 0x05 -> highest is 2
    busWrite(A_MASK, 32'h7F);
    expectObs(K_STAT, 8'h0, {28'd0, 1'b1, 3'd2}, "R7 highest of 0x05");
    expectObs(K_IRQ, 8'h0, 32'h0, "R8 irq not yet risen");
    @(negedge clk);
    expectObs(K_IRQ, 8'h0, 32'h1, "R8 irq one cycle later");

    busWrite(A_CAUSE, 32'h41);
    expectObs(K_STAT, 8'h0, {28'd0, 1'b1, 3'd6}, "R7 highest of 0x41");
    busWrite(A_CAUSE, 32'h01);
    expectObs(K_STAT, 8'h0, {28'd0, 1'b1, 3'd0}, "R7 only bit 0");

    // R4 event sets and sticks
    busWrite(A_CAUSE, 32'h0);
    @(negedge clk);
    evtIn = 7'h10;
    @(negedge clk);
    evtIn = 7'h00;
    @(negedge clk);
    expectObs(K_RDATA, A_CAUSE, 32'h10, "R4 event sticky");
    expectObs(K_STAT, 8'h0, {28'd0, 1'b1, 3'd4}, "R4 event pending index");

    // R5 event wins over a simultaneous write of zero
    @(negedge clk);
    evtIn = 7'h08;
    busSel = 1'b1; busWr = 1'b1; busAddr = A_CAUSE; busWdata = 32'h0;
    @(negedge clk);
    evtIn = 7'h00; busSel = 1'b0; busWr = 1'b0;
    expectObs(K_RDATA, A_CAUSE, 32'h08, "R5 event beats write zero");

    // R10 other address
    busWrite(A_OTHER, 32'h7F);
    expectObs(K_RDATA, A_CAUSE, 32'h08, "R10 cause untouched");
    expectObs(K_RDATA, A_MASK, 32'h7F, "R10 mask untouched");
    expectObs(K_RDATA, A_OTHER, 32'h0, "R10 other reads zero");

    // R6 and R8: masking everything drops irq one cycle later
    busWrite(A_MASK, 32'h0);
    expectObs(K_STAT, 8'h0, 32'h0, "R6 masked all");
    expectObs(K_IRQ, 8'h0, 32'h1, "R8 irq still high");
    @(negedge clk);
    expectObs(K_IRQ, 8'h0, 32'h0, "R8 irq dropped");

    @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule